// File: doc/BRIEF.md
# In-Order Issue Register Scoreboard

This block sits between the decode stage and the execution units of a processor that issues in program order. Instructions complete out of order because the units have different latencies. The block keeps one pending-write flag for each general-purpose register. A set flag means an instruction already in flight will still overwrite that register. A clear flag means the register file copy is current.

Each cycle the block receives at most one issue request. A request names a destination, two sources and a target unit. The block either dispatches the request or stalls it, and when it stalls it reports why. On dispatch it forwards the source operands read from its register file and marks the destination pending. Up to two completion ports return results each cycle. A completion writes its result into the register file and clears the destination's flag, and it does so before the issue check of the same cycle is evaluated.

Top module: `regscore_top`

## Requirements
- R1: After reset every pending flag is clear and every register reads as zero.
- R2: A valid request whose source register (rs or rt, non-zero) is pending stalls with `stall_why` = 1 (read-after-write). This code takes priority over all others.
- R3: A valid request whose non-zero destination is pending, with no source hazard, stalls with `stall_why` = 2 (write-after-write).
- R4: A valid request whose requested unit has its `fu_busy` bit set, with no data hazard, stalls with `stall_why` = 3. The busy bits of other units have no effect on the request.
- R5: A request with no hazard dispatches in the same cycle with `stall_why` = 0. `disp_rd`, `disp_fu` and both source operand values are presented, and the destination's pending flag is set from the next cycle on.
- R6: A completion port with `cmp_valid` set writes its data into the named register and clears that register's flag. Both ports act independently in the same cycle.
- R7: Register 0 is never pending, always reads zero, ignores completions, and never causes a stall.
- R8: When a completion and an issue name the same register in the same cycle, the issue check sees the flag already cleared. Operands take the completing data. A dispatch to that register sets the flag again.
- R9: A stalled request changes no pending flag and no register.
- R10: When both completion ports name the same register in one cycle, port 1's data is the value kept and the value bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_rd | input | AW | Destination register |
| iss_rs | input | AW | First source register |
| iss_rt | input | AW | Second source register |
| iss_fu | input | FUW | Requested functional unit |
| fu_busy | input | NFU | Per-unit structural busy |
| iss_stall | output | 1 | Request held this cycle |
| stall_why | output | 2 | 0 none, 1 RAW, 2 WAW, 3 unit busy |
| disp_valid | output | 1 | Request dispatched this cycle |
| disp_fu | output | FUW | Unit receiving the dispatch |
| disp_rd | output | AW | Destination of the dispatch |
| disp_rs_val | output | DW | First operand value |
| disp_rt_val | output | DW | Second operand value |
| cmp_valid | input | NCMP | Completion port valid |
| cmp_rd | input | NCMP*AW | Completion destinations, port p at bits p*AW |
| cmp_data | input | NCMP*DW | Completion results, port p at bits p*DW |
| pend_bits | output | NREG | Pending-write flags |

## Verification
The bench sweeps every combination of pending state for registers 1 to 3 against every choice of rd, rs and rt among registers 0 to 3. It does this once with the requested unit busy and once with only the other units busy. The sweep separates RAW from WAW priority, shows that register 0 is exempt, and shows that only the requested unit's busy bit matters. Directed sequences then cover completion in the same cycle as an issue to the same register, both ports writing one register, and operand values returned after out-of-order completions. These show that clearing, bypass and port priority are ordered correctly.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_RAW  = 2'd1,
    SW_WAW  = 2'd2,
    SW_UNIT = 2'd3
  } stall_code_e;

  // Priority of stall causes: data read hazard, then write order, then unit
  function automatic stall_code_e rank_stall(input logic raw, input logic waw,
                                             input logic unit);
    if (raw)       return SW_RAW;
    else if (waw)  return SW_WAW;
    else if (unit) return SW_UNIT;
    else           return SW_NONE;
  endfunction
endpackage

// File: rtl/scb_pend.sv
module scb_pend #(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_idx,
  input  logic [NREG-1:0] clr_vec,
  output logic [NREG-1:0] pend,
  output logic [NREG-1:0] pend_eff
);
  for (genvar g = 0; g < NREG; g++) begin : g_bit
    if (g == 0) begin : g_zero
      assign pend[g] = 1'b0;
    end else begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_vec[g]) | (set_en && (set_idx == AW'(g)));
      end
      assign pend[g] = q;
    end
  end
  assign pend_eff = pend & ~clr_vec;
endmodule

// File: rtl/scb_rf.sv
module scb_rf #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NCMP = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCMP-1:0]    wv,
  input  logic [NCMP*AW-1:0] wa,
  input  logic [NCMP*DW-1:0] wd,
  input  logic [AW-1:0]      ra0,
  input  logic [AW-1:0]      ra1,
  output logic [DW-1:0]      rd0,
  output logic [DW-1:0]      rd1
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int p = 0; p < NCMP; p++)
        if (wv[p] && wa[p*AW +: AW] != '0) mem[wa[p*AW +: AW]] <= wd[p*DW +: DW];
    end
  end

  // Read with bypass from this cycle's writes; higher port wins
  function automatic logic [DW-1:0] fetch(input logic [AW-1:0] a,
                                          input logic [DW-1:0] stored,
                                          input logic [NCMP-1:0] v,
                                          input logic [NCMP*AW-1:0] adr,
                                          input logic [NCMP*DW-1:0] dat);
    logic [DW-1:0] r;
    r = stored;
    for (int p = 0; p < NCMP; p++)
      if (v[p] && adr[p*AW +: AW] == a) r = dat[p*DW +: DW];
    if (a == '0) r = '0;
    return r;
  endfunction

  assign rd0 = fetch(ra0, mem[ra0], wv, wa, wd);
  assign rd1 = fetch(ra1, mem[ra1], wv, wa, wd);
endmodule

// File: rtl/scb_hazard.sv
module scb_hazard
  import scb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NFU  = 4,
  parameter int AW   = $clog2(NREG),
  parameter int FUW  = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic            iss_valid,
  input  logic [AW-1:0]   rd,
  input  logic [AW-1:0]   rs,
  input  logic [AW-1:0]   rt,
  input  logic [FUW-1:0]  fu,
  input  logic [NREG-1:0] pend_eff,
  input  logic [NFU-1:0]  fu_busy,
  output logic            raw_hit,
  output logic            waw_hit,
  output logic            unit_hit,
  output logic            go,
  output stall_code_e     why
);
  logic unit_sel;
  assign unit_sel = (int'(fu) < NFU) ? fu_busy[fu] : 1'b1;

  assign raw_hit  = iss_valid && ((rs != '0 && pend_eff[rs]) ||
                                  (rt != '0 && pend_eff[rt]));
  assign waw_hit  = iss_valid && rd != '0 && pend_eff[rd];
  assign unit_hit = iss_valid && unit_sel;
  assign why      = rank_stall(raw_hit, waw_hit, unit_hit);
  assign go       = iss_valid && (why == SW_NONE);
endmodule

// File: rtl/regscore_top.sv
module regscore_top
  import scb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NFU  = 4,
  parameter int NCMP = 2,
  parameter int AW   = $clog2(NREG),
  parameter int FUW  = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [AW-1:0]      iss_rd,
  input  logic [AW-1:0]      iss_rs,
  input  logic [AW-1:0]      iss_rt,
  input  logic [FUW-1:0]     iss_fu,
  input  logic [NFU-1:0]     fu_busy,
  output logic               iss_stall,
  output logic [1:0]         stall_why,
  output logic               disp_valid,
  output logic [FUW-1:0]     disp_fu,
  output logic [AW-1:0]      disp_rd,
  output logic [DW-1:0]      disp_rs_val,
  output logic [DW-1:0]      disp_rt_val,
  input  logic [NCMP-1:0]    cmp_valid,
  input  logic [NCMP*AW-1:0] cmp_rd,
  input  logic [NCMP*DW-1:0] cmp_data,
  output logic [NREG-1:0]    pend_bits
);
  logic [NREG-1:0] clr_vec;
  logic [NREG-1:0] pend_eff;
  logic            raw_hit, waw_hit, unit_hit, go;
  stall_code_e     why;

  always_comb begin
    clr_vec = '0;
    for (int p = 0; p < NCMP; p++)
      if (cmp_valid[p]) clr_vec[cmp_rd[p*AW +: AW]] = 1'b1;
  end

  scb_pend #(.NREG(NREG), .AW(AW)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_en(go), .set_idx(iss_rd),
    .clr_vec(clr_vec), .pend(pend_bits), .pend_eff(pend_eff));

  scb_hazard #(.NREG(NREG), .NFU(NFU), .AW(AW), .FUW(FUW)) u_haz (
    .iss_valid(iss_valid), .rd(iss_rd), .rs(iss_rs), .rt(iss_rt), .fu(iss_fu),
    .pend_eff(pend_eff), .fu_busy(fu_busy), .raw_hit(raw_hit),
    .waw_hit(waw_hit), .unit_hit(unit_hit), .go(go), .why(why));

  scb_rf #(.NREG(NREG), .DW(DW), .NCMP(NCMP), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wv(cmp_valid), .wa(cmp_rd), .wd(cmp_data),
    .ra0(iss_rs), .ra1(iss_rt), .rd0(disp_rs_val), .rd1(disp_rt_val));

  assign iss_stall  = iss_valid && !go;
  assign stall_why  = why;
  assign disp_valid = go;
  assign disp_fu    = iss_fu;
  assign disp_rd    = iss_rd;
endmodule

// File: rtl/regscore_chk.sv
module regscore_chk #(
  parameter int NREG = 32,
  parameter int NCMP = 2,
  parameter int AW   = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic [AW-1:0]      iss_rd,
  input logic               iss_stall,
  input logic [1:0]         stall_why,
  input logic               disp_valid,
  input logic [AW-1:0]      disp_rd,
  input logic [NCMP-1:0]    cmp_valid,
  input logic [NCMP*AW-1:0] cmp_rd,
  input logic [NREG-1:0]    pend_bits,
  input logic               raw_hit
);
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_bits[0] == 1'b0);

  p_go_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (!iss_stall && stall_why == 2'd0));

  p_set_after_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_rd != '0) |=> pend_bits[$past(disp_rd)]);

  p_raw_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit |-> (!disp_valid && stall_why == 2'd1));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid[0] && !(disp_valid && disp_rd == cmp_rd[AW-1:0]))
      |=> !pend_bits[$past(cmp_rd[AW-1:0])]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_stall && cmp_valid == '0) |=> $stable(pend_bits));

  p_waw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rd != '0 && pend_bits[iss_rd] && cmp_valid == '0 && !raw_hit)
      |-> stall_why == 2'd2);
endmodule

bind regscore_top regscore_chk #(.NREG(NREG), .NCMP(NCMP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_rd(iss_rd),
  .iss_stall(iss_stall), .stall_why(stall_why), .disp_valid(disp_valid),
  .disp_rd(disp_rd), .cmp_valid(cmp_valid), .cmp_rd(cmp_rd),
  .pend_bits(pend_bits), .raw_hit(raw_hit));

// File: tb/regscore_top_test.sv
module regscore_top_test;
  localparam int NREG = 32, DW = 32, NFU = 4, NCMP = 2, AW = 5, FUW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [AW-1:0] iss_rd = '0, iss_rs = '0, iss_rt = '0;
  logic [FUW-1:0] iss_fu = '0;
  logic [NFU-1:0] fu_busy = '0;
  logic iss_stall, disp_valid;
  logic [1:0] stall_why;
  logic [FUW-1:0] disp_fu;
  logic [AW-1:0] disp_rd;
  logic [DW-1:0] disp_rs_val, disp_rt_val;
  logic [NCMP-1:0] cmp_valid = '0;
  logic [NCMP*AW-1:0] cmp_rd = '0;
  logic [NCMP*DW-1:0] cmp_data = '0;
  logic [NREG-1:0] pend_bits;

  always #4 clk = ~clk;

  regscore_top uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [NREG-1:0] m_busy;
  logic [DW-1:0]   m_reg [NREG];
  int seq = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus with an independent expectation
  task automatic step(input string req, input bit v, input int rd, input int rs,
                      input int rt, input int fu, input logic [NFU-1:0] fb,
                      input bit c0v, input int c0r, input logic [DW-1:0] c0d,
                      input bit c1v, input int c1r, input logic [DW-1:0] c1d);
    logic [NREG-1:0] eb;
    logic [DW-1:0] ers, ert;
    bit raw, waw, unt, go;
    int ew;
    @(negedge clk);
    iss_valid = v; iss_rd = AW'(rd); iss_rs = AW'(rs); iss_rt = AW'(rt);
    iss_fu = FUW'(fu); fu_busy = fb;
    cmp_valid = {c1v, c0v};
    cmp_rd = {AW'(c1r), AW'(c0r)};
    cmp_data = {c1d, c0d};
    #1;
    eb = m_busy;
    if (c0v) eb[c0r] = 1'b0;
    if (c1v) eb[c1r] = 1'b0;
    raw = v && ((rs != 0 && eb[rs]) || (rt != 0 && eb[rt]));
    waw = v && rd != 0 && eb[rd];
    unt = v && fb[fu];
    ew = raw ? 1 : waw ? 2 : unt ? 3 : 0;
    go = v && ew == 0;
    ers = m_reg[rs]; ert = m_reg[rt];
    if (c0v && c0r == rs) ers = c0d;
    if (c1v && c1r == rs) ers = c1d;
    if (c0v && c0r == rt) ert = c0d;
    if (c1v && c1r == rt) ert = c1d;
    if (rs == 0) ers = '0;
    if (rt == 0) ert = '0;
    check(req, "stall_why", 64'(stall_why), 64'(ew));
    check(req, "iss_stall", 64'(iss_stall), 64'(v && !go));
    check(req, "disp_valid", 64'(disp_valid), 64'(go));
    if (go) begin
      check(req, "disp_rd", 64'(disp_rd), 64'(rd));
      check(req, "disp_fu", 64'(disp_fu), 64'(fu));
      check(req, "rs operand", 64'(disp_rs_val), 64'(ers));
      check(req, "rt operand", 64'(disp_rt_val), 64'(ert));
    end
    @(posedge clk);
    if (c0v && c0r != 0) m_reg[c0r] = c0d;
    if (c1v && c1r != 0) m_reg[c1r] = c1d;
    m_busy = eb;
    if (go && rd != 0) m_busy[rd] = 1'b1;
    #1;
    check(req, "pend_bits", 64'(pend_bits), 64'(m_busy));
  endtask

  task automatic idle_step(input string req);
    step(req, 0, 0, 0, 0, 0, '0, 0, 0, '0, 0, 0, '0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_busy = '0;
    for (int i = 0; i < NREG; i++) m_reg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, flags clear and registers zero
    #1;
    check("R1", "pend_bits after reset", 64'(pend_bits), 64'd0);
    step("R1", 1, 9, 5, 6, 0, '0, 0, 0, '0, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0, 1, 9, 32'h0, 0, 0, '0);

    // Sweep: pending mask over regs 1..3, every rd/rs/rt in 0..3, unit busy or not
    for (int mask = 0; mask < 8; mask++)
      for (int rd = 0; rd < 4; rd++)
        for (int rs = 0; rs < 4; rs++)
          for (int rt = 0; rt < 4; rt++)
            for (int fb = 0; fb < 2; fb++) begin
              int fu;
              logic [NFU-1:0] oh;
              string tag;
              fu = (rd + rs + rt) % NFU;
              oh = NFU'(1) << fu;
              seq++;
              // R6: two ports clear regs 1 and 2 with fresh data, then reg 3
              step("R6", 0, 0, 0, 0, 0, '0, 1, 1, DW'(32'h1000_0000 + seq),
                   1, 2, DW'(32'h2000_0000 + seq));
              step("R6", 0, 0, 0, 0, 0, '0, 1, 3, DW'(32'h3000_0000 + seq),
                   0, 0, '0);
              for (int r = 1; r < 4; r++)
                if (mask[r-1]) step("R5", 1, r, 0, 0, 0, '0, 0, 0, '0, 0, 0, '0);
              if (rs != 0 && mask[rs-1] || rt != 0 && mask[rt-1]) tag = "R2";
              else if (rd != 0 && mask[rd-1]) tag = "R3";
              else if (fb == 1) tag = "R4";
              else if (rd == 0 || rs == 0 || rt == 0) tag = "R7";
              else tag = "R5";
              // R4: only the requested unit's busy bit matters
              step(tag, 1, rd, rs, rt, fu, fb ? oh : ~oh, 0, 0, '0, 0, 0, '0);
              // R9: repeating a stalled request leaves everything unchanged
              if (tag == "R2" || tag == "R3" || tag == "R4")
                step("R9", 1, rd, rs, rt, fu, fb ? oh : ~oh, 0, 0, '0, 0, 0, '0);
            end

    // R8: completion and issue on the same register in one cycle
    step("R8", 0, 0, 0, 0, 0, '0, 1, 1, 32'h11, 1, 2, 32'h22);
    step("R8", 1, 4, 0, 0, 1, '0, 0, 0, '0, 0, 0, '0);
    step("R8", 1, 4, 4, 0, 1, '0, 1, 4, 32'hCAFE, 0, 0, '0);
    step("R8", 1, 5, 4, 0, 2, '0, 0, 0, '0, 0, 0, '0);
    step("R8", 0, 0, 0, 0, 0, '0, 0, 0, '0, 1, 4, 32'hBEEF);
    // R10: both ports on one register, port 1 wins for bypass and storage
    step("R10", 1, 6, 7, 7, 3, '0, 1, 7, 32'hAAAA, 1, 7, 32'h5555);
    step("R10", 0, 0, 0, 0, 0, '0, 1, 6, 32'h66, 0, 0, '0);
    step("R10", 1, 8, 7, 6, 0, '0, 0, 0, '0, 0, 0, '0);
    // R6: out-of-order completion of two in-flight writes
    step("R6", 1, 10, 0, 0, 0, '0, 1, 8, 32'h88, 0, 0, '0);
    step("R6", 1, 11, 0, 0, 1, '0, 0, 0, '0, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0, 1, 11, 32'hB0B, 0, 0, '0);
    step("R6", 1, 12, 11, 10, 2, '0, 0, 0, '0, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0, 1, 10, 32'hA0A, 1, 12, 32'hC0C);
    step("R6", 1, 13, 11, 10, 2, '0, 0, 0, '0, 0, 0, '0);
    // R7: completion to register 0 is ignored
    step("R7", 0, 0, 0, 0, 0, '0, 1, 0, 32'hDEAD, 0, 0, '0);
    step("R7", 1, 0, 0, 0, 0, '0, 0, 0, '0, 0, 0, '0);
    idle_step("R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule